// File: doc/BRIEF.md
# Watchdog Timer with Reload Control

This block is a bus-mapped watchdog. A 16-bit down-counter counts in ticks. A prescaler divides the system clock to make the ticks, and with the default 1 MHz clock one tick is 10 ms. Software writes a preset value to the count address, which stores the value but does not load it. Software then writes the control byte with the enable and reload bits set, and that write copies the preset into the counter. Software services the timer by writing the reload bit again before the counter runs out. A read of the count address returns the live count, not the preset, so software can read how many ticks are left.

When the counter steps from 1 to 0 while enabled, the block sets a warning flag. If the interrupt option is set, it pulses a non-maskable-interrupt request. Otherwise it raises a system-reset request for a fixed number of clock cycles. The block does not restart itself after expiry. A preset of 1 gives an expiry one tick after the reload, which can be used to force a quick restart.

Top module: `wdog_timer`

## Requirements
- R1: After reset the live count, the preset, enable, interrupt option and warning flag are all zero. `sys_rst_req` and `nmi_req` are low.
- R2: A write to address 0x10 stores the preset only: `bus_be[0]` writes bits 7:0 and `bus_be[1]` writes bits 15:8. A read of 0x10 returns the live count, and a read of any unmapped address returns 0. `bus_rdata` is valid in the cycle after the read request.
- R3: The control byte sits in lane 0 at address 0x16. Bit 0 is enable, bit 3 is the interrupt option and bit 7 is the warning flag. Bit 2, the reload command, always reads as 0.
- R4: A control write with bits 0 and 2 both set copies the preset into the counter and clears the prescaler. A control write with bit 2 set and bit 0 clear loads nothing.
- R5: While enabled with a nonzero count, the counter drops by one every CLK_PER_TICK cycles. The first decrement comes CLK_PER_TICK cycles after the reload.
- R6: Writing enable to 0 freezes the count.
- R7: When the counter steps from 1 to 0 while enabled, the warning flag is set. The counter then stays at 0.
- R8: On expiry with the interrupt option clear, `sys_rst_req` is high for exactly RST_CYCLES cycles, starting after the clock edge on which the counter reaches 0.
- R9: On expiry with the interrupt option set, `nmi_req` pulses high for one cycle and `sys_rst_req` stays low.
- R10: Writing 1 to control bit 7 clears the warning flag. Writing 0 to bit 7 leaves the flag as it is.
- R11: A preset of 1 followed by enable plus reload expires exactly CLK_PER_TICK cycles after the reload write.
- R12: A reload before expiry restarts the full timeout from the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| sys_rst_req | output | 1 | System-reset request pulse |
| nmi_req | output | 1 | Non-maskable-interrupt request pulse |

## Verification
A fault in the prescaler or the counter shows up in the live count. A read returns a value that moves off the line `preset - floor(cycles/CLK_PER_TICK)` within one tick of the fault. A fault in the expiry path shows up as a reset or interrupt pulse in the wrong cycle, of the wrong length, or on the wrong output. The pulse is compared against the cycle number computed from the reload edge. A fault in the control register shows up on the next readback of the control byte.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // byte offsets inside the register window
   localparam int unsigned OFS_COUNT = 32'h10;
   localparam int unsigned OFS_CTRL  = 32'h16;
   // control byte bit positions
   localparam int unsigned CB_EN     = 0;
   localparam int unsigned CB_RELOAD = 2;
   localparam int unsigned CB_NMI    = 3;
   localparam int unsigned CB_WARN   = 7;

   typedef struct packed {
      logic warn;
      logic nmi_en;
      logic enable;
   } wd_ctrl_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned DIV = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_direct
         assign tick_o = run_i & ~clr_i;
      end else begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pre_q <= '0;
            else if (clr_i)        pre_q <= '0;
            else if (run_i)        pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
         end

         assign tick_o = run_i & ~clr_i & (pre_q == LAST);

         // R5
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] preset_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (load_i)                    cnt_q <= preset_i;
      else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o    = cnt_q;
   assign expire_o = tick_i & ~load_i & (cnt_q == ONE);

   // R6
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !tick_i) |=> $stable(cnt_q));
   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R7
   cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry #(
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic nmi_en_i,
   output logic rst_o,
   output logic nmi_o
);
   logic nmi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nmi_q <= 1'b0;
      else        nmi_q <= expire_i & nmi_en_i;
   end
   assign nmi_o = nmi_q;

   generate
      if (RST_CYCLES == 1) begin : g_single
         logic r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= 1'b0;
            else        r_q <= expire_i & ~nmi_en_i;
         end
         assign rst_o = r_q;
      end else begin : g_stretch
         localparam int unsigned RW = $clog2(RST_CYCLES + 1);
         logic [RW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       left_q <= '0;
            else if (expire_i && !nmi_en_i)   left_q <= RW'(RST_CYCLES);
            else if (left_q != '0)            left_q <= left_q - 1'b1;
         end
         assign rst_o = (left_q != '0);
      end
   endgenerate

   // R8
   rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && !nmi_en_i) |=> rst_o);
   // R9
   nmi_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && nmi_en_i) |=> nmi_o);
   // R9
   nmi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |=> !nmi_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int unsigned CLK_PER_TICK = 10000,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned RST_CYCLES   = 16,
   parameter int unsigned ADDR_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_be,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              sys_rst_req,
   output logic              nmi_req
);
   import wdog_pkg::*;

   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);

   generate
      if (CLK_PER_TICK < 1) begin : g_bad_div
         $error("CLK_PER_TICK must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
         $error("CNT_W must lie in 2..16");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too narrow for the register window");
      end
   endgenerate

   // ---- bus decode
   logic wr_cnt, wr_ctl, rd_any;
   assign wr_cnt = bus_valid &  bus_write & (bus_addr == A_COUNT);
   assign wr_ctl = bus_valid &  bus_write & (bus_addr == A_CTRL) & bus_be[0];
   assign rd_any = bus_valid & ~bus_write;

   // ---- preset register with byte lanes
   logic [15:0] preset_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) preset_q <= '0;
      else if (wr_cnt) begin
         if (bus_be[0]) preset_q[7:0]  <= bus_wdata[7:0];
         if (bus_be[1]) preset_q[15:8] <= bus_wdata[15:8];
      end
   end

   // ---- control register
   wd_ctrl_t ctl_q;
   logic     load, expire, tick, run;
   logic [CNT_W-1:0] cnt;

   assign load = wr_ctl & bus_wdata[CB_RELOAD] & bus_wdata[CB_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else begin
         if (wr_ctl) begin
            ctl_q.enable <= bus_wdata[CB_EN];
            ctl_q.nmi_en <= bus_wdata[CB_NMI];
         end
         if (expire)                          ctl_q.warn <= 1'b1;
         else if (wr_ctl && bus_wdata[CB_WARN]) ctl_q.warn <= 1'b0;
      end
   end

   assign run = ctl_q.enable & (cnt != '0);

   wdog_prescaler #(.DIV(CLK_PER_TICK)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr_i(load), .run_i(run), .tick_o(tick)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_i(load), .preset_i(preset_q[CNT_W-1:0]),
      .tick_i(tick), .cnt_o(cnt), .expire_o(expire)
   );

   wdog_expiry #(.RST_CYCLES(RST_CYCLES)) u_exp (
      .clk(clk), .rst_n(rst_n), .expire_i(expire), .nmi_en_i(ctl_q.nmi_en),
      .rst_o(sys_rst_req), .nmi_o(nmi_req)
   );

   // ---- registered read path
   logic [7:0] ctl_byte;
   always_comb begin
      ctl_byte          = '0;
      ctl_byte[CB_EN]   = ctl_q.enable;
      ctl_byte[CB_NMI]  = ctl_q.nmi_en;
      ctl_byte[CB_WARN] = ctl_q.warn;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else if (rd_any) begin
         if (bus_addr == A_COUNT)     bus_rdata <= 16'(cnt);
         else if (bus_addr == A_CTRL) bus_rdata <= {8'h00, ctl_byte};
         else                         bus_rdata <= '0;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_wdata[15:8], bus_wdata[6:4], bus_wdata[1], preset_q};

   // R3
   reload_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == A_CTRL) |=> !bus_rdata[CB_RELOAD]);
   // R7
   warn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> ctl_q.warn);
   // R4
   no_load_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !bus_wdata[CB_EN]) |=> !ctl_q.enable && $stable(cnt));
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
   localparam int CLK_PERIOD = 10;
   localparam int P   = 5;
   localparam int RST = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        sys_rst_req, nmi_req;

   int checks = 0;
   int errors = 0;
   int edge_n = 0;
   int ew = 0;
   logic [15:0] v, v2;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) edge_n <= edge_n + 1;

   wdog_timer #(.CLK_PER_TICK(P), .CNT_W(16), .RST_CYCLES(RST), .ADDR_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req), .nmi_req(nmi_req)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s got %0h expected %0h", req, what, got, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      ew = edge_n;
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d, output int er);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata; er = edge_n;
      bus_valid = 1'b0;
   endtask

   function automatic int exp_cnt(input int preset, input int j);
      return (j / P >= preset) ? 0 : preset - j / P;
   endfunction

   // watch the two request outputs for n cycles after the last write
   task automatic watch(input int n, input int exp_at, input bit nmi_mode, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         begin
            int j;
            bit er_rst, er_nmi;
            j = edge_n - ew;
            er_rst = !nmi_mode && (j >= exp_at) && (j < exp_at + RST);
            er_nmi = nmi_mode && (j == exp_at);
            chk(sys_rst_req == er_rst, req, $sformatf("sys_rst_req at j=%0d", j), sys_rst_req, er_rst);
            chk(nmi_req == er_nmi, req, $sformatf("nmi_req at j=%0d", j), nmi_req, er_nmi);
         end
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int er;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(sys_rst_req == 1'b0, "R1", "sys_rst_req", sys_rst_req, 0);
      chk(nmi_req == 1'b0, "R1", "nmi_req", nmi_req, 0);
      rd(8'h10, v, er); chk(v == 16'h0, "R1", "count", v, 0);
      rd(8'h16, v, er); chk(v == 16'h0, "R1", "control", v, 0);

      // R2 preset is not the live count; unmapped reads zero
      wr(8'h10, 16'h0007, 2'b11);
      rd(8'h10, v, er); chk(v == 16'h0, "R2", "live count after preset write", v, 0);
      rd(8'h20, v, er); chk(v == 16'h0, "R2", "unmapped read", v, 0);

      // R4 reload without enable loads nothing; R3 reload bit reads 0
      wr(8'h16, 16'h0004, 2'b01);
      rd(8'h10, v, er); chk(v == 16'h0, "R4", "count after reload w/o enable", v, 0);
      rd(8'h16, v, er); chk(v == 16'h0, "R3", "control after reload w/o enable", v, 0);

      // R2 byte lanes, R4 load
      wr(8'h10, 16'h1234, 2'b11);
      wr(8'h10, 16'hAB99, 2'b10);
      wr(8'h16, 16'h0005, 2'b01);
      rd(8'h10, v, er); chk(v == 16'hAB34, "R2", "lane-merged preset loaded", v, 16'hAB34);
      rd(8'h16, v, er); chk(v == 16'h0001, "R3", "control readback", v, 1);

      // R6 disable freezes the count
      wr(8'h16, 16'h0000, 2'b01);
      rd(8'h10, v, er);
      repeat (4 * P) @(negedge clk);
      rd(8'h10, v2, er);
      chk(v == v2, "R6", "count frozen while disabled", v2, v);
      chk(v != 16'h0 && v <= 16'hAB34, "R6", "frozen count in range", v, 16'hAB34);

      // R5 R7 R8 full sweep, preset 3
      wr(8'h10, 16'd3, 2'b11);
      wr(8'h16, 16'h0005, 2'b01);
      for (int i = 0; i < 3 * P + RST + 4; i++) begin
         int j, e;
         bit er_rst;
         rd(8'h10, v, er);
         j = er - ew - 1;
         e = exp_cnt(3, j);
         chk(v == 16'(e), "R5", $sformatf("count at j=%0d", j), v, e);
         j = edge_n - ew;
         er_rst = (j >= 3 * P) && (j < 3 * P + RST);
         chk(sys_rst_req == er_rst, "R8", $sformatf("reset pulse at j=%0d", j), sys_rst_req, er_rst);
         chk(nmi_req == 1'b0, "R8", "no interrupt in reset mode", nmi_req, 0);
      end
      repeat (2 * P) @(negedge clk);
      rd(8'h10, v, er); chk(v == 16'h0, "R7", "count stays at zero", v, 0);
      rd(8'h16, v, er); chk(v == 16'h0081, "R7", "warn flag set", v, 16'h81);

      // R10 warn clear semantics
      wr(8'h16, 16'h0001, 2'b01);
      rd(8'h16, v, er); chk(v == 16'h0081, "R10", "write 0 keeps warn", v, 16'h81);
      wr(8'h16, 16'h0081, 2'b01);
      rd(8'h16, v, er); chk(v == 16'h0001, "R10", "write 1 clears warn", v, 1);

      // R9 interrupt mode
      wr(8'h10, 16'd2, 2'b11);
      wr(8'h16, 16'h000D, 2'b01);
      watch(2 * P + RST + 4, 2 * P, 1'b1, "R9");
      rd(8'h16, v, er); chk(v == 16'h0089, "R9", "control after interrupt expiry", v, 16'h89);
      wr(8'h16, 16'h0080, 2'b01);

      // R11 preset of one expires after one tick
      wr(8'h10, 16'd1, 2'b11);
      wr(8'h16, 16'h0005, 2'b01);
      watch(P + RST + 3, P, 1'b0, "R11");

      // R12 service restarts the full timeout
      wr(8'h16, 16'h0080, 2'b01);
      wr(8'h10, 16'd4, 2'b11);
      wr(8'h16, 16'h0005, 2'b01);
      watch(3 * P - 2, 4 * P, 1'b0, "R12");
      wr(8'h16, 16'h0005, 2'b01);
      rd(8'h10, v, er); chk(v == 16'd4, "R12", "count restored by service", v, 4);
      watch(4 * P + RST + 3, 4 * P, 1'b0, "R12");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule